// File: doc/BRIEF.md
# Programmable Halfband Decimator

This block lowers a stream of signed samples by a factor of two with a halfband FIR filter. Samples arrive one at a time, each marked by a one-cycle input strobe. They are stored alternately in two 16-deep history buffers, one for even-numbered and one for odd-numbered samples. After every second sample, a short microprogram runs over a single multiply-accumulate datapath and produces one filtered output, marked by a one-cycle output strobe.

The microprogram and the coefficients are loaded at run time through a settings port made of a strobe, an 8-bit address and a 32-bit data word. Each program word picks three history entries and one coefficient. It also says whether the product starts a new sum or adds to the running one, whether the current sum is sent to the output, and whether the program ends. The filter's symmetry is used by adding the two mirrored odd-tap samples before the multiply. The centre tap is added straight from the even buffer with a fixed weight. The 40-bit sum is rounded and clamped to an 18-bit output.

Top module: `hbd_halfband_decim`

## Requirements
- R1: A settings write with address 124 stores `set_data[17:0]` as a signed coefficient. The first write of a burst goes to coefficient slot 0, and each write on the following clock cycles goes to the next slot. Any cycle without such a write starts the next burst again at slot 0.
- R2: A settings write with address 125 stores `set_data[19:0]` as a program word. The slot order and the burst restart rule are the same as in R1.
- R3: A settings write to any address other than 124 and 125 changes neither the coefficients nor the program.
- R4: Program word layout: bit 19 emit, bit 18 accumulate, bit 17 load, bit 16 last. Bits 15:12 select the even sample, bits 11:8 select the first odd sample, bits 7:4 select the second odd sample and bits 3:0 select the coefficient slot.
- R5: After reset, the first input strobe writes the even buffer and the next writes the odd buffer, and this alternation repeats. The cycle after each odd write, the program starts at word 0. It executes one word per cycle up to and including the first word with last set, so there is exactly one output per input pair when the program holds one emit word.
- R6: A history select value `a` picks the a-th most recent sample of that buffer, with 0 the newest. The newest odd sample is the one whose write started the sequence. The buffer positions are captured when the sequence starts.
- R7: A word with load sets the sum to (odd sample A + odd sample B) × coefficient + even sample × 2^16. A word with accumulate but no load adds (A + B) × coefficient to the sum. Load wins when both are set, and a word with neither leaves the sum unchanged.
- R8: A word with emit drives `out_stb` high for exactly one cycle, two cycles after the word is fetched. At that point `out_sample` takes the rounded value of the sum as it stood before that word's own update. `out_sample` holds its value between strobes.
- R9: Rounding adds 2^15 to the 40-bit sum and then shifts it right arithmetically by 16 bits, so exact halves round toward plus infinity.
- R10: A rounded value above 131071 gives 131071, and one below -131072 gives -131072.
- R11: Synchronous reset clears the history contents and positions, the even/odd alternation, the sequencer, the sum, `out_stb` and `out_sample`. Coefficients and program words keep their loaded values.
- R12: A word with both emit and load sends out the sum left by the previous sequence while the new sum starts from that word's product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings address (124 coefficients, 125 program) |
| set_data | input | 32 | Settings write data |
| in_stb | input | 1 | Input sample valid, one cycle per sample |
| in_sample | input | 17 | Signed input sample |
| out_stb | output | 1 | Output sample valid, one cycle per emitted result |
| out_sample | output | 18 | Signed rounded and saturated filter output |

## Verification
The functions that can meet in one cycle are the output emit and the sum reload. When a word carries both, the output register must capture the old sum on the same edge that overwrites it. The bench provokes this by loading a second program that puts emit and load on word 0. Each output is then judged against the reference result of the preceding sequence, including the hand-over from the first program, whose last sum was saturated. A second overlap, an even-sample write that lands while a sequence is still reading, happens on every pair, because samples arrive eight cycles apart. Every output is compared with a direct FIR evaluation of the sample history.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int SAMP_W       = 17;
    localparam int COEF_W       = 18;
    localparam int OUT_W        = 18;
    localparam int ACC_W        = 40;
    localparam int FLD_W        = 4;
    localparam int HIST_D       = 1 << FLD_W;
    localparam int SUM_W        = SAMP_W + 1;
    localparam int PROD_W       = SUM_W + COEF_W;
    localparam int CTRL_W       = 4 + 4 * FLD_W;
    localparam int SET_AW       = 8;
    localparam int SET_DW       = 32;
    localparam int CENTER_SHIFT = 16;
    localparam int ROUND_SHIFT  = 16;

    localparam logic [SET_AW-1:0] SET_COEF  = SET_AW'(124);
    localparam logic [SET_AW-1:0] SET_TABLE = SET_AW'(125);

    localparam logic signed [ACC_W-1:0] ACC_BIAS = ACC_W'(1) <<< (ROUND_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] OUT_HI   = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] OUT_LO   = ~OUT_HI;

    // One program word; field order is the decoded bit layout.
    typedef struct packed {
        logic             emit;
        logic             accum;
        logic             load;
        logic             last;
        logic [FLD_W-1:0] even_sel;
        logic [FLD_W-1:0] odd_sel_a;
        logic [FLD_W-1:0] odd_sel_b;
        logic [FLD_W-1:0] coef_sel;
    } uword_t;

    // Operand bundle handed from the fetch stage to the MAC stage.
    typedef struct packed {
        logic                     valid;
        logic                     emit;
        logic                     accum;
        logic                     load;
        logic [SUM_W-1:0]         pair_sum;
        logic [COEF_W-1:0]        coef;
        logic [SAMP_W-1:0]        center;
    } mac_op_t;

    function automatic logic [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] shifted;
        shifted = (a + ACC_BIAS) >>> ROUND_SHIFT;
        if (shifted > OUT_HI)
            return OUT_HI[OUT_W-1:0];
        else if (shifted < OUT_LO)
            return OUT_LO[OUT_W-1:0];
        else
            return shifted[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/hbd_burst_mem.sv
// Run-time loaded store: consecutive-cycle writes on one settings address
// fill slots in ascending order; a quiet cycle rewinds the slot index.
module hbd_burst_mem
    import hbd_pkg::*;
#(
    parameter int                W      = COEF_W,
    parameter int                ADDR_W = FLD_W,
    parameter logic [SET_AW-1:0] KEY    = SET_COEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic [SET_AW-1:0] set_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_sel,
    output logic [W-1:0]      rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0]      mem [DEPTH];
    logic [ADDR_W-1:0] slot;
    logic              hit;

    assign hit = set_stb && (set_addr == KEY) && !rst;

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (hit)
            slot <= slot + ADDR_W'(1);
        else
            slot <= '0;
    end

    always_ff @(posedge clk) begin
        if (hit)
            mem[slot] <= wr_data;
    end

    assign rd_data = mem[rd_sel];
endmodule

// File: rtl/hbd_hist_buf.sv
// Circular sample history with NRD relative read ports.
module hbd_hist_buf
    import hbd_pkg::*;
#(
    parameter int W       = SAMP_W,
    parameter int DEPTH_W = FLD_W,
    parameter int NRD     = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [W-1:0]                  wr_data,
    output logic [DEPTH_W-1:0]            wptr,
    input  logic [DEPTH_W-1:0]            base,
    input  logic [NRD-1:0][DEPTH_W-1:0]   rd_sel,
    output logic [NRD-1:0][W-1:0]         rd_data
);
    localparam int DEPTH = 1 << DEPTH_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
            wptr      <= wptr + DEPTH_W'(1);
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            logic [DEPTH_W-1:0] idx;
            assign idx        = base - DEPTH_W'(1) - rd_sel[r];
            assign rd_data[r] = mem[idx];
        end
    endgenerate
endmodule

// File: rtl/hbd_sequencer.sv
// Even/odd steering of input samples and the program counter.
module hbd_sequencer
    import hbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_stb,
    input  logic [FLD_W-1:0] even_wptr,
    input  logic [FLD_W-1:0] odd_wptr,
    input  logic             word_last,
    output logic             even_wr,
    output logic             odd_wr,
    output logic             run,
    output logic [FLD_W-1:0] pc,
    output logic [FLD_W-1:0] even_base,
    output logic [FLD_W-1:0] odd_base
);
    logic odd_next;

    assign even_wr = in_stb && !odd_next;
    assign odd_wr  = in_stb &&  odd_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            odd_next  <= 1'b0;
            run       <= 1'b0;
            pc        <= '0;
            even_base <= '0;
            odd_base  <= '0;
        end else begin
            if (in_stb)
                odd_next <= !odd_next;
            if (odd_wr) begin
                run       <= 1'b1;
                pc        <= '0;
                even_base <= even_wptr;
                odd_base  <= odd_wptr + FLD_W'(1);
            end else if (run) begin
                pc <= pc + FLD_W'(1);
                if (word_last)
                    run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hbd_mac.sv
// Pre-add register stage followed by multiply, accumulate and output rounding.
module hbd_mac
    import hbd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue,
    input  uword_t                   word,
    input  logic signed [SAMP_W-1:0] even_smp,
    input  logic signed [SAMP_W-1:0] odd_a,
    input  logic signed [SAMP_W-1:0] odd_b,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     out_stb,
    output logic [OUT_W-1:0]         out_sample
);
    mac_op_t                  op_q;
    logic signed [SUM_W-1:0]  ps;
    logic signed [COEF_W-1:0] cf;
    logic signed [SAMP_W-1:0] ctr;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  center_term;
    logic signed [ACC_W-1:0]  acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else begin
            op_q.valid    <= issue;
            op_q.emit     <= issue && word.emit;
            op_q.accum    <= issue && word.accum;
            op_q.load     <= issue && word.load;
            op_q.pair_sum <= SUM_W'(odd_a) + SUM_W'(odd_b);
            op_q.coef     <= coef;
            op_q.center   <= even_smp;
        end
    end

    assign ps          = op_q.pair_sum;
    assign cf          = op_q.coef;
    assign ctr         = op_q.center;
    assign prod        = PROD_W'(ps) * PROD_W'(cf);
    assign prod_ext    = ACC_W'(prod);
    assign center_term = ACC_W'(ctr) <<< CENTER_SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            out_stb    <= 1'b0;
            out_sample <= '0;
        end else begin
            out_stb <= op_q.valid && op_q.emit;
            if (op_q.valid && op_q.emit)
                out_sample <= round_sat(acc);
            if (op_q.valid && op_q.load)
                acc <= prod_ext + center_term;
            else if (op_q.valid && op_q.accum)
                acc <= acc + prod_ext;
        end
    end
endmodule

// File: rtl/hbd_halfband_decim.sv
module hbd_halfband_decim
    import hbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic [SET_AW-1:0] set_addr,
    input  logic [SET_DW-1:0] set_data,
    input  logic              in_stb,
    input  logic [SAMP_W-1:0] in_sample,
    output logic              out_stb,
    output logic [OUT_W-1:0]  out_sample
);
    logic                     even_wr;
    logic                     odd_wr;
    logic                     run;
    logic [FLD_W-1:0]         pc;
    logic [FLD_W-1:0]         even_wptr;
    logic [FLD_W-1:0]         odd_wptr;
    logic [FLD_W-1:0]         even_base;
    logic [FLD_W-1:0]         odd_base;
    logic [CTRL_W-1:0]        word_bits;
    uword_t                   cur_word;
    logic [COEF_W-1:0]        coef_val;
    logic [0:0][SAMP_W-1:0]   even_rd;
    logic [1:0][SAMP_W-1:0]   odd_rd;
    logic                     unused_hi;

    assign unused_hi = ^set_data[SET_DW-1:CTRL_W];
    assign cur_word  = uword_t'(word_bits);

    hbd_burst_mem #(.W(COEF_W), .ADDR_W(FLD_W), .KEY(SET_COEF)) u_coef (
        .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
        .wr_data(set_data[COEF_W-1:0]), .rd_sel(cur_word.coef_sel), .rd_data(coef_val)
    );

    hbd_burst_mem #(.W(CTRL_W), .ADDR_W(FLD_W), .KEY(SET_TABLE)) u_prog (
        .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
        .wr_data(set_data[CTRL_W-1:0]), .rd_sel(pc), .rd_data(word_bits)
    );

    hbd_sequencer u_seq (
        .clk(clk), .rst(rst), .in_stb(in_stb),
        .even_wptr(even_wptr), .odd_wptr(odd_wptr), .word_last(cur_word.last),
        .even_wr(even_wr), .odd_wr(odd_wr), .run(run), .pc(pc),
        .even_base(even_base), .odd_base(odd_base)
    );

    hbd_hist_buf #(.W(SAMP_W), .DEPTH_W(FLD_W), .NRD(1)) u_even (
        .clk(clk), .rst(rst), .wr_en(even_wr), .wr_data(in_sample),
        .wptr(even_wptr), .base(even_base), .rd_sel(cur_word.even_sel), .rd_data(even_rd)
    );

    hbd_hist_buf #(.W(SAMP_W), .DEPTH_W(FLD_W), .NRD(2)) u_odd (
        .clk(clk), .rst(rst), .wr_en(odd_wr), .wr_data(in_sample),
        .wptr(odd_wptr), .base(odd_base),
        .rd_sel({cur_word.odd_sel_a, cur_word.odd_sel_b}), .rd_data(odd_rd)
    );

    hbd_mac u_mac (
        .clk(clk), .rst(rst), .issue(run), .word(cur_word),
        .even_smp(even_rd[0]), .odd_a(odd_rd[1]), .odd_b(odd_rd[0]), .coef(coef_val),
        .out_stb(out_stb), .out_sample(out_sample)
    );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
    import hbd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_stb,
    input logic             odd_wr,
    input logic             run,
    input logic [FLD_W-1:0] pc,
    input logic             word_last,
    input logic             out_stb
);
    logic par;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)
            par <= 1'b0;
        else if (in_stb)
            par <= !par;
    end

    AST_ODD_PHASE: assert property (@(posedge clk) disable iff (rst)
        odd_wr == (in_stb && par)); // R5

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        odd_wr |=> (run && pc == '0)); // R5

    AST_LAST_HALTS: assert property (@(posedge clk) disable iff (rst)
        (run && word_last && !odd_wr) |=> !run); // R5

    AST_EMIT_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> $past(run, 2)); // R8

    always @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RESET_QUIET: assert (!out_stb && !run); // R11
        end
    end
endmodule

bind hbd_halfband_decim hbd_checker u_chk (
    .clk(clk), .rst(rst), .in_stb(in_stb), .odd_wr(odd_wr), .run(run),
    .pc(pc), .word_last(cur_word.last), .out_stb(out_stb)
);

// File: tb/tb_hbd_halfband_decim.sv
module tb_hbd_halfband_decim;
    import hbd_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              set_stb = 1'b0;
    logic [SET_AW-1:0] set_addr = '0;
    logic [SET_DW-1:0] set_data = '0;
    logic              in_stb = 1'b0;
    logic [SAMP_W-1:0] in_sample = '0;
    logic              out_stb;
    logic [OUT_W-1:0]  out_sample;

    always #10 clk = ~clk;

    hbd_halfband_decim dut (
        .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
        .in_stb(in_stb), .in_sample(in_sample), .out_stb(out_stb), .out_sample(out_sample)
    );

    typedef struct { longint val; string tag; } exp_t;
    exp_t   sb[$];
    int     tests = 0;
    int     fails = 0;
    int     coef_m[8];
    int     x_hist[4096];
    int     n_in = 0;
    longint last_acc = 0;
    bit     emit_prev = 0;
    string  cur_tag = "R6";
    bit     done_flag = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint xs(input int i);
        return (i < 0) ? 64'sd0 : longint'(x_hist[i]);
    endfunction

    // Direct FIR sum over the sample history.
    function automatic longint model_acc();
        longint a;
        a = xs(n_in - 16) * 65536;
        for (int i = 0; i < 8; i++)
            a += longint'(coef_m[i]) * (xs(n_in - 1 - 2 * i) + xs(n_in - 1 - 2 * (15 - i)));
        return a;
    endfunction

    function automatic longint rnd_sat(input longint a);
        longint r;
        r = (a + 32768) >>> 16;
        if (r > 131071) r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    task automatic feed(input int s);
        longint a;
        @(posedge clk);
        in_stb    <= 1'b1;
        in_sample <= SAMP_W'(s);
        x_hist[n_in] = s;
        n_in++;
        if (n_in % 2 == 0) begin
            a = model_acc();
            sb.push_back('{val: rnd_sat(emit_prev ? last_acc : a), tag: cur_tag});
            last_acc = a;
        end
        @(posedge clk);
        in_stb <= 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic set_wr(input logic [SET_AW-1:0] a, input logic [SET_DW-1:0] d);
        @(posedge clk);
        set_stb  <= 1'b1;
        set_addr <= a;
        set_data <= d;
    endtask

    task automatic set_idle();
        @(posedge clk);
        set_stb <= 1'b0;
    endtask

    task automatic load_coefs(input int c[8]);
        for (int i = 0; i < 8; i++) begin
            set_wr(SET_COEF, SET_DW'(c[i]));
            coef_m[i] = c[i];
        end
        set_idle();
    endtask

    function automatic logic [SET_DW-1:0] uw(input bit e, input bit ac, input bit ld, input bit lst,
                                             input int ev, input int oa, input int ob, input int cs);
        return {12'd0, e, ac, ld, lst, 4'(ev), 4'(oa), 4'(ob), 4'(cs)};
    endfunction

    // Program A: load on word 0, accumulate 1..7, emit+last on word 8.
    task automatic load_prog_a();
        for (int i = 0; i < 8; i++)
            set_wr(SET_TABLE, uw(0, i != 0, i == 0, 0, 7, i, 15 - i, i));
        set_wr(SET_TABLE, uw(1, 0, 0, 1, 0, 0, 0, 0));
        set_idle();
        emit_prev = 0;
    endtask

    // Program B: emit and load share word 0, last on word 7.
    task automatic load_prog_b();
        for (int i = 0; i < 8; i++)
            set_wr(SET_TABLE, uw(i == 0, i != 0, i == 0, i == 7, 7, i, 15 - i, i));
        set_idle();
        emit_prev = 1;
    endtask

    task automatic drain(input string tag);
        repeat (30) @(posedge clk);
        check(tag, longint'(sb.size()), 0);
    endtask

    always @(negedge clk) begin
        if (!rst && out_stb) begin
            if (sb.size() == 0) begin
                check("R5 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, longint'($signed(out_sample)), e.val);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset out_stb", longint'(out_stb), 0);
        check("R11 reset out_sample", longint'($signed(out_sample)), 0);
        @(posedge clk);
        rst <= 1'b0;

        load_coefs('{-40, 150, -420, 900, -1650, 3200, -6250, 20500});
        load_prog_a();

        // R6: impulse on an even slot, then on an odd slot
        cur_tag = "R6 even impulse";
        for (int i = 0; i < 10; i++) feed(0);
        feed(1000);
        for (int i = 0; i < 36; i++) feed(0);
        cur_tag = "R6 odd impulse";
        feed(-2000);
        for (int i = 0; i < 36; i++) feed(0);
        // R7: step and ramp exercise load and accumulate over all taps (R4 layout)
        cur_tag = "R7 step";
        for (int i = 0; i < 40; i++) feed(5000);
        cur_tag = "R4 ramp";
        for (int i = 0; i < 34; i++) feed(i * 37 - 600);
        drain("R5 pending outputs");

        // R3: writes to other addresses leave coefficients and program alone
        set_wr(8'd126, 32'hFFFF_FFFF);
        set_wr(8'd0, 32'h000F_FFFF);
        set_wr(8'd123, 32'h0001_2345);
        set_idle();
        cur_tag = "R3 foreign address";
        for (int i = 0; i < 34; i++) feed((i % 5) * 900 - 1800);
        drain("R5 pending outputs");

        // R1: a short burst, a gap, then a full burst that must start at slot 0
        set_wr(SET_COEF, 32'd9999);
        set_wr(SET_COEF, 32'd9999);
        set_wr(SET_COEF, 32'd9999);
        set_idle();
        set_idle();
        load_coefs('{25, -110, 330, -760, 1500, -2900, 6100, -19800});
        cur_tag = "R1 burst restart";
        for (int i = 0; i < 34; i++) feed((i % 3 == 0) ? 4000 : -700);
        drain("R5 pending outputs");

        // R9: exact halves round toward plus infinity
        load_coefs('{32768, 0, 0, 0, 0, 0, 0, 0});
        cur_tag = "R9 rounding";
        for (int i = 0; i < 11; i++) feed(0);
        feed(1);
        feed(0); feed(0); feed(0);
        feed(-1);
        for (int i = 0; i < 20; i++) feed(0);
        feed(0);
        feed(3);
        for (int i = 0; i < 4; i++) feed(0);
        drain("R5 pending outputs");

        // R10: saturation in both directions
        load_coefs('{131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071});
        cur_tag = "R10 saturation";
        for (int i = 0; i < 34; i++) feed(65535);
        for (int i = 0; i < 34; i++) feed(-65536);
        drain("R5 pending outputs");

        // R12: emit and load in the same word (R2 program reload)
        load_coefs('{-40, 150, -420, 900, -1650, 3200, -6250, 20500});
        load_prog_b();
        cur_tag = "R12 emit with load";
        for (int i = 0; i < 40; i++) feed((i % 7) * 1200 - 3000);
        drain("R2 pending outputs");

        // R11: reset keeps coefficients and program, clears the rest
        @(posedge clk);
        rst <= 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset out_sample cleared", longint'($signed(out_sample)), 0);
        check("R11 reset out_stb cleared", longint'(out_stb), 0);
        @(posedge clk);
        rst <= 1'b0;
        n_in = 0;
        last_acc = 0;
        for (int i = 0; i < 4096; i++) x_hist[i] = 0;
        cur_tag = "R11 after reset";
        for (int i = 0; i < 5; i++) feed(0);
        feed(7000);
        for (int i = 0; i < 34; i++) feed(0);
        drain("R11 pending outputs");

        done_flag = 1;
        finish_run();
    end
endmodule